// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed 16-bit operands and adds the product into a wide signed accumulator register, one operation per clock. It suits filter taps, dot products and correlators, where a long run of products is summed before the result is read. When a sum would go past the accumulator's range, the register clamps to the nearest limit instead of wrapping. A sticky flag records that clamping happened somewhere in the run.

A synchronous clear returns the accumulator to zero and drops the flag. Clear takes priority over an accumulate requested in the same cycle. The product is formed combinationally inside the block. By default it is built from four half-width partial products summed at their weights, and a parameter can select a single direct multiply instead. The adder, the saturation logic and the register follow the multiplier, so a result is visible one clock after its operands are presented.

Top module: `sat_mac_unit`

## Requirements
- R1: While `rstN` is low at a rising clock edge, the accumulator becomes 0 and the overflow flag becomes 0 after that edge, whatever the other inputs are.
- R2: With `enableIn` high and `clearIn` low, the accumulator after the edge equals its old value plus the two's-complement product `opA * opB`, when that sum lies within the signed 40-bit range.
- R3: If that sum exceeds +2^39-1, the accumulator loads +2^39-1 (0x7FFFFFFFFF) and the overflow flag is set.
- R4: If that sum is below -2^39, the accumulator loads -2^39 (0x8000000000) and the overflow flag is set.
- R5: With `clearIn` high, the accumulator becomes 0 and the overflow flag becomes 0 after the edge.
- R6: When `clearIn` and `enableIn` are both high, the clear is performed and the product is discarded, so the accumulator reads 0.
- R7: With both `enableIn` and `clearIn` low, the accumulator and the overflow flag keep their values, whatever the operands are.
- R8: Once set, the overflow flag stays set through later in-range accumulations and idle cycles, until a clear or a reset.
- R9: The extreme operand values give exact products: -32768 * -32768 adds +2^30, and -32768 * 32767 adds -1073709056.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset, active low |
| clearIn | input | 1 | Clear the accumulator and the overflow flag |
| enableIn | input | 1 | Accumulate this cycle's product |
| opA | input | 16 | Signed multiplicand |
| opB | input | 16 | Signed multiplier |
| accOut | output | 40 | Signed accumulator contents |
| ovfFlag | output | 1 | Sticky saturation indicator |

## Verification
Two pairs of functions can fall in the same cycle. A clear can arrive with an accumulate request, and a clear can arrive in the cycle that would otherwise saturate. The bench drives both: it asserts `clearIn` and `enableIn` together with large operands, and it asserts clear at the moment the accumulator sits at a limit with the flag raised. Each clock, a behavioural model that works in 64-bit integers and clamps explicitly computes the expected accumulator and flag. The bench compares these with the ports, so a dropped priority or a flag that survives the clear shows up as a miscompare in the next cycle.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;

  // Strobes issued by the control module to the datapath each cycle.
  typedef struct packed {
    logic doClear;
    logic doAccum;
  } macStrobes_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import sat_mac_pkg::*;
(
  input  logic        clearIn,
  input  logic        enableIn,
  output macStrobes_t strobes
);

  // Clear outranks accumulate (R6): an accumulate strobe is only issued
  // when no clear is requested in the same cycle.
  always_comb begin
    strobes.doClear = clearIn;
    strobes.doAccum = enableIn & ~clearIn;
  end

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int OP_W  = 16,
  parameter bit SPLIT = 1'b1
) (
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [2*OP_W-1:0] prod
);

  localparam int PROD_W = 2 * OP_W;
  localparam int HALF   = OP_W / 2;
  localparam int EXT    = PROD_W - HALF;

  if (SPLIT) begin : g_split
    // Index 0 holds the unsigned low half, index 1 the signed high half;
    // every piece is widened to the product width so that modular
    // arithmetic gives the exact two's-complement result (R9).
    logic [PROD_W-1:0] aPart [2];
    logic [PROD_W-1:0] bPart [2];
    logic [PROD_W-1:0] quad  [4];

    assign aPart[0] = {{EXT{1'b0}}, opA[HALF-1:0]};
    assign aPart[1] = {{EXT{opA[OP_W-1]}}, opA[OP_W-1:HALF]};
    assign bPart[0] = {{EXT{1'b0}}, opB[HALF-1:0]};
    assign bPart[1] = {{EXT{opB[OP_W-1]}}, opB[OP_W-1:HALF]};

    // Four half-width partial products, each shifted to its weight.
    for (genvar q = 0; q < 4; q++) begin : g_quad
      localparam int IA    = q / 2;
      localparam int IB    = q % 2;
      localparam int SHIFT = (IA + IB) * HALF;
      logic [PROD_W-1:0] raw;
      assign raw     = aPart[IA] * bPart[IB];
      assign quad[q] = raw << SHIFT;
    end

    always_comb begin
      prod = '0;
      for (int q = 0; q < 4; q++) prod = prod + quad[q];
    end
  end else begin : g_direct
    logic [PROD_W-1:0] aWide;
    logic [PROD_W-1:0] bWide;
    assign aWide = {{OP_W{opA[OP_W-1]}}, opA};
    assign bWide = {{OP_W{opB[OP_W-1]}}, opB};
    assign prod  = aWide * bWide;
  end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import sat_mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic               clk,
  input  logic               rstN,
  input  macStrobes_t        strobes,
  input  logic [2*OP_W-1:0]  prod,
  output logic [ACC_W-1:0]   accOut,
  output logic               ovfFlag
);

  localparam int PROD_W = 2 * OP_W;
  localparam int GUARD  = ACC_W + 1 - PROD_W;
  localparam logic [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] acc;
  logic             ovf;
  logic [ACC_W:0]   sumWide;
  logic             posOvf;
  logic             negOvf;
  logic [ACC_W-1:0] nextAcc;

  // One extra bit of headroom: the two top bits disagree exactly when
  // the true sum has left the signed ACC_W range.
  assign sumWide = {acc[ACC_W-1], acc} + {{GUARD{prod[PROD_W-1]}}, prod};
  assign posOvf  = ~sumWide[ACC_W] &  sumWide[ACC_W-1];
  assign negOvf  =  sumWide[ACC_W] & ~sumWide[ACC_W-1];

  always_comb begin
    if (posOvf)      nextAcc = MAXV;
    else if (negOvf) nextAcc = MINV;
    else             nextAcc = sumWide[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
      ovf <= 1'b0;
    end else if (strobes.doClear) begin
      acc <= '0;
      ovf <= 1'b0;
    end else if (strobes.doAccum) begin
      acc <= nextAcc;
      if (posOvf || negOvf) ovf <= 1'b1;
    end
  end

  assign accOut  = acc;
  assign ovfFlag = ovf;

  // Accumulating a positive product at the upper limit pins it there.
  assert_pos_sat_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doAccum && acc == MAXV && !prod[PROD_W-1] && prod != '0)
      |=> (acc == MAXV && ovf));

  // Accumulating a negative product at the lower limit pins it there.
  assert_neg_sat_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doAccum && acc == MINV && prod[PROD_W-1])
      |=> (acc == MINV && ovf));

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doClear |=> (acc == '0 && !ovf));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.doClear && !strobes.doAccum) |=> ($stable(acc) && $stable(ovf)));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !strobes.doClear) |=> ovf);

endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit
  import sat_mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  parameter bit SPLIT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearIn,
  input  logic             enableIn,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  output logic [ACC_W-1:0] accOut,
  output logic             ovfFlag
);

  macStrobes_t       strobes;
  logic [2*OP_W-1:0] prod;

  mac_ctrl u_ctrl (
    .clearIn  (clearIn),
    .enableIn (enableIn),
    .strobes  (strobes)
  );

  mac_mult #(.OP_W(OP_W), .SPLIT(SPLIT)) u_mult (
    .opA  (opA),
    .opB  (opB),
    .prod (prod)
  );

  mac_datapath #(.OP_W(OP_W), .ACC_W(ACC_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .prod    (prod),
    .accOut  (accOut),
    .ovfFlag (ovfFlag)
  );

endmodule

// File: tb/sat_mac_unit_bench.sv
`timescale 1ns/1ps
module sat_mac_unit_bench;

  localparam longint MAXV = 64'sd549755813887;   // 2^39 - 1
  localparam longint MINV = -64'sd549755813888;  // -2^39

  logic clk = 1'b0;
  logic rstN, clearIn, enableIn;
  logic signed [15:0] opA, opB;
  logic [39:0] accOut;
  logic ovfFlag;

  always #4 clk = ~clk;

  sat_mac_unit u_sat_mac_unit (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .enableIn(enableIn),
    .opA(opA), .opB(opB), .accOut(accOut), .ovfFlag(ovfFlag)
  );

  int     vectors = 0;
  int     fails   = 0;
  bit     done    = 0;
  bit     checkOn = 0;
  string  curReq  = "R1";
  longint mAcc    = 0;
  bit     mOvf    = 0;

  // At a falling edge: compare the ports with the model, then drive the
  // next inputs and advance the model to the value due after the next rise.
  task automatic step(input bit r, input bit c, input bit e,
                      input logic signed [15:0] a, input logic signed [15:0] b);
    longint s;
    longint got;
    @(negedge clk);
    if (checkOn) begin
      got = longint'($signed(accOut));
      vectors++;
      if (got != mAcc || ovfFlag !== mOvf) begin
        fails++;
        $display("FAIL %s: acc=%0d ovf=%0b expected acc=%0d ovf=%0b",
                 curReq, got, ovfFlag, mAcc, mOvf);
      end
    end
    rstN = r; clearIn = c; enableIn = e; opA = a; opB = b;
    if (!r || c) begin
      mAcc = 0; mOvf = 0;
    end else if (e) begin
      s = mAcc + longint'(a) * longint'(b);
      if (s > MAXV)      begin mAcc = MAXV; mOvf = 1; end
      else if (s < MINV) begin mAcc = MINV; mOvf = 1; end
      else mAcc = s;
    end
  endtask

  initial begin
    rstN = 0; clearIn = 0; enableIn = 0; opA = 0; opB = 0;
    // R1: reset state, then compare every cycle
    step(0, 0, 1, 16'sd100, 16'sd100);
    step(0, 0, 1, 16'sd100, 16'sd100);
    checkOn = 1;
    step(1, 0, 0, 0, 0);
    // R2: plain accumulation with mixed signs
    curReq = "R2";
    step(1, 0, 1, 16'sd3, 16'sd7);
    step(1, 0, 1, -16'sd12, 16'sd45);
    step(1, 0, 1, -16'sd300, -16'sd200);
    step(1, 0, 1, 16'sd1234, -16'sd4321);
    // R7: idle cycles hold the value despite changing operands
    curReq = "R7";
    step(1, 0, 0, 16'sd32767, 16'sd32767);
    step(1, 0, 0, -16'sd5, 16'sd9);
    // R9: extreme operands
    curReq = "R9";
    step(1, 1, 0, 0, 0);
    step(1, 0, 1, -16'sd32768, -16'sd32768);
    step(1, 0, 1, -16'sd32768, 16'sd32767);
    step(1, 0, 1, 16'sd32767, 16'sd32767);
    step(1, 0, 0, 0, 0);
    // R3: drive to the positive limit and beyond
    curReq = "R3";
    step(1, 1, 0, 0, 0);
    for (int i = 0; i < 530; i++) step(1, 0, 1, -16'sd32768, -16'sd32768);
    // R8: flag stays set through in-range steps and idle cycles
    curReq = "R8";
    step(1, 0, 1, -16'sd1000, 16'sd1000);
    step(1, 0, 0, 0, 0);
    step(1, 0, 1, 16'sd7, -16'sd7);
    // R5: clear while saturated drops value and flag
    curReq = "R5";
    step(1, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    // R4: drive to the negative limit and beyond
    curReq = "R4";
    for (int i = 0; i < 530; i++) step(1, 0, 1, 16'sd32767, -16'sd32768);
    step(1, 0, 1, 16'sd1, -16'sd1);
    // R6: clear and enable together, first while saturated, then from nonzero
    curReq = "R6";
    step(1, 1, 1, -16'sd32768, 16'sd32767);
    step(1, 0, 1, 16'sd50, 16'sd60);
    step(1, 1, 1, 16'sd32767, 16'sd32767);
    step(1, 0, 0, 0, 0);
    // R1: reset in the middle of a run overrides enable
    curReq = "R1";
    step(1, 0, 1, 16'sd999, 16'sd999);
    step(0, 0, 1, 16'sd999, 16'sd999);
    step(1, 0, 0, 0, 0);
    // R2/R6: random mix of clear, enable and operands
    curReq = "R2_R6_mix";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(1, r[3:0] == 4'd0, r[4] | r[5],
           16'($urandom), 16'($urandom));
    end
    step(1, 0, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule